// File: doc/BRIEF.md
# DDR2 Power-Up Bring-Up Sequencer

This block owns the DDR2 command bus from reset until the memory is ready for ordinary traffic. After reset it keeps clock enable low and drives NOP for a start-up interval. That interval is a parameter, so a bench can use a short value in place of the long nominal delay. It then raises clock enable and plays a fixed list of eleven commands, with a programmed gap after each one. When the list is finished it raises a ready flag for the rest of the memory controller.

The list runs as follows:
- precharge-all;
- extended register loads to registers 2, 3 and 1;
- a mode register load that resets the memory's DLL;
- a second precharge-all;
- two auto-refreshes;
- a mode register load with the DLL reset cleared;
- two extended register 1 loads, which first set the output-driver calibration field to its default and then leave calibration.

The mode and extended register contents come from parameters. The sequencer forces only the DLL-reset bit and the calibration field.

Top module: `ddr2_init_seq`

## Requirements
- R1: While `rst_n` is low, `cke` is 0, the command pins {cs_n,ras_n,cas_n,we_n} read 4'b0111 (NOP), `ba` and `addr` are 0, and `init_done` is 0.
- R2: After `rst_n` rises, `cke` stays 0 with NOP on the bus for at least STARTUP_CYC and at most STARTUP_CYC+3 cycles. It then goes to 1 and stays 1 until the next reset.
- R3: The first command (precharge-all) appears exactly one cycle after `cke` rises.
- R4: Exactly eleven commands are issued, each lasting one cycle. The encodings are PCH=4'b0010, ARF=4'b0001 and mode load=4'b0000. The order is PCH, load, load, load, load, PCH, ARF, ARF, load, load, load.
- R5: The mode loads select their target through `ba`, in this order: 2, 3, 1, 0, 0, 1, 1. Register 2 and register 3 receive EMR2_VAL and EMR3_VAL unchanged.
- R6: The first `ba`=0 load writes MR_VAL with address bit 8 (DLL reset) set. The second writes MR_VAL with bit 8 cleared.
- R7: The three register 1 loads write EMR1_VAL with the calibration field `addr[9:7]` forced to 3'b000, then 3'b111, then 3'b000. All other bits stay as in EMR1_VAL.
- R8: A precharge-all drives `addr` with only bit 10 set and `ba`=0. An auto-refresh and every NOP drive `addr`=0 and `ba`=0.
- R9: The distance from a mode load to the next command is T_MRD cycles. After the DLL-reset load the distance is T_DLL cycles instead.
- R10: The distance from a precharge-all to the next command is T_RP cycles. From an auto-refresh it is T_RFC cycles. All gap parameters are at least 2.
- R11: `init_done` rises exactly T_MRD cycles after the last command. It then stays 1, with `cke`=1 and NOP on the bus, until reset.
- R12: A reset in the middle of the list or during the start-up wait restarts the whole sequence from the start-up wait.
- R13: A reset after `init_done` clears the flag at once, and the whole sequence runs again after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address / mode register select |
| addr | output | ADDR_W | Address / mode register contents |
| init_done | output | 1 | Memory initialised, held until reset |

## Verification
Reset is the only input, so the patterns are reset timings:
- **A clean power-up** checks order, encodings, register contents and every gap against values computed independently of the design.
- **A second reset pulse partway through the start-up wait** shows that the wait counter restarts and does not resume.
- **A reset just after the DLL-reset load** shows that the list pointer and gap timer restart from the top rather than continuing.
- **A reset after the ready flag** shows that the flag and clock enable drop at once and that the full list, long DLL hold-off included, is replayed.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_ARF = 4'b0001,
    CMD_PCH = 4'b0010,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [2:0] {
    ST_WAIT = 3'd0,
    ST_CKE  = 3'd1,
    ST_CMD  = 3'd2,
    ST_GAP  = 3'd3,
    ST_DONE = 3'd4
  } state_e;

  localparam int unsigned NUM_STEPS = 11;
  localparam int unsigned STEP_W    = $clog2(NUM_STEPS);

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr2_init_timer.sv
module ddr2_init_timer
  import ddr2_init_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load) begin
      cnt_n = load_val;
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(RST_VAL);
    end else begin
      cnt_q <= cnt_n;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/ddr2_init_steps.sv
module ddr2_init_steps
  import ddr2_init_pkg::*;
#(
  parameter int unsigned   ADDR_W      = 14,
  parameter int unsigned   BA_W        = 3,
  parameter int unsigned   CNT_W       = 8,
  parameter int unsigned   T_MRD       = 2,
  parameter int unsigned   T_RP        = 3,
  parameter int unsigned   T_RFC       = 9,
  parameter int unsigned   T_DLL       = 200,
  parameter logic [13:0]   MR_VAL      = 14'h0042,
  parameter logic [13:0]   EMR1_VAL    = 14'h0004,
  parameter logic [13:0]   EMR2_VAL    = 14'h0000,
  parameter logic [13:0]   EMR3_VAL    = 14'h0000,
  parameter int unsigned   DLL_RST_BIT = 8,
  parameter int unsigned   OCD_LSB     = 7,
  parameter int unsigned   AP_BIT      = 10
) (
  input  logic [STEP_W-1:0] step,
  output cmd_e              cmd,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  gap
);

  localparam logic [ADDR_W-1:0] DLL_MASK  = ADDR_W'(1) << DLL_RST_BIT;
  localparam logic [ADDR_W-1:0] OCD_MASK  = ADDR_W'(3'b111) << OCD_LSB;
  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << AP_BIT;
  localparam logic [ADDR_W-1:0] MR_A      = ADDR_W'(MR_VAL);
  localparam logic [ADDR_W-1:0] EMR1_A    = ADDR_W'(EMR1_VAL);
  localparam logic [ADDR_W-1:0] MR_DLL_RST   = MR_A | DLL_MASK;
  localparam logic [ADDR_W-1:0] MR_RUN       = MR_A & ~DLL_MASK;
  localparam logic [ADDR_W-1:0] EMR1_OCD_OFF = EMR1_A & ~OCD_MASK;
  localparam logic [ADDR_W-1:0] EMR1_OCD_DEF = EMR1_A | OCD_MASK;

  always_comb begin
    cmd  = CMD_NOP;
    ba   = '0;
    addr = '0;
    gap  = CNT_W'(T_MRD);
    case (step)
      STEP_W'(0), STEP_W'(5): begin
        cmd  = CMD_PCH;
        addr = ALL_BANKS;
        gap  = CNT_W'(T_RP);
      end
      STEP_W'(1): begin
        cmd  = CMD_MRS;
        ba   = BA_W'(2);
        addr = ADDR_W'(EMR2_VAL);
      end
      STEP_W'(2): begin
        cmd  = CMD_MRS;
        ba   = BA_W'(3);
        addr = ADDR_W'(EMR3_VAL);
      end
      STEP_W'(3), STEP_W'(10): begin
        cmd  = CMD_MRS;
        ba   = BA_W'(1);
        addr = EMR1_OCD_OFF;
      end
      STEP_W'(4): begin
        cmd  = CMD_MRS;
        addr = MR_DLL_RST;
        gap  = CNT_W'(T_DLL);
      end
      STEP_W'(6), STEP_W'(7): begin
        cmd  = CMD_ARF;
        gap  = CNT_W'(T_RFC);
      end
      STEP_W'(8): begin
        cmd  = CMD_MRS;
        addr = MR_RUN;
      end
      STEP_W'(9): begin
        cmd  = CMD_MRS;
        ba   = BA_W'(1);
        addr = EMR1_OCD_DEF;
      end
      default: begin
        cmd  = CMD_NOP;
      end
    endcase
  end

endmodule

// File: rtl/ddr2_init_fsm.sv
module ddr2_init_fsm
  import ddr2_init_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expired,
  input  logic [CNT_W-1:0]  gap,
  output state_e            state_nxt,
  output logic [STEP_W-1:0] step_nxt,
  output logic              load,
  output logic [CNT_W-1:0]  load_val
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  state_e            state_q;
  logic [STEP_W-1:0] step_q;

  always_comb begin
    state_nxt = state_q;
    step_nxt  = step_q;
    load      = 1'b0;
    case (state_q)
      ST_WAIT: begin
        if (expired) state_nxt = ST_CKE;
      end
      ST_CKE: begin
        state_nxt = ST_CMD;
        step_nxt  = '0;
      end
      ST_CMD: begin
        state_nxt = ST_GAP;
        load      = 1'b1;
      end
      ST_GAP: begin
        if (expired) begin
          if (step_q == LAST_STEP) begin
            state_nxt = ST_DONE;
          end else begin
            state_nxt = ST_CMD;
            step_nxt  = step_q + STEP_W'(1);
          end
        end
      end
      ST_DONE: begin
        state_nxt = ST_DONE;
      end
      default: begin
        state_nxt = ST_WAIT;
      end
    endcase
  end

  // command cycle counts as the first cycle of the gap
  assign load_val = gap - CNT_W'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      step_q  <= '0;
    end else begin
      state_q <= state_nxt;
      step_q  <= step_nxt;
    end
  end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int unsigned ADDR_W      = 14,
  parameter int unsigned BA_W        = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STARTUP_CYC = 10_000_000,
  parameter int unsigned T_MRD       = 2,
  parameter int unsigned T_RP        = 3,
  parameter int unsigned T_RFC       = 26,
  parameter int unsigned T_DLL       = 200,
  parameter logic [13:0] MR_VAL      = 14'h0042,
  parameter logic [13:0] EMR1_VAL    = 14'h0004,
  parameter logic [13:0] EMR2_VAL    = 14'h0000,
  parameter logic [13:0] EMR3_VAL    = 14'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  localparam int unsigned MAX_WAIT = max_u(max_u(STARTUP_CYC, T_DLL),
                                           max_u(T_RFC, max_u(T_RP, T_MRD)));
  localparam int unsigned CNT_W    = $clog2(MAX_WAIT + 1);

  // reset: asynchronous assert, synchronous release
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = sync_q[SYNC_STAGES-1];

  state_e            state_nxt;
  logic [STEP_W-1:0] step_nxt;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_expired;
  cmd_e              rom_cmd;
  logic [BA_W-1:0]   rom_ba;
  logic [ADDR_W-1:0] rom_addr;
  logic [CNT_W-1:0]  rom_gap;
  logic [CNT_W-1:0]  gap_q;

  ddr2_init_timer #(
    .CNT_W   (CNT_W),
    .RST_VAL (STARTUP_CYC - 1)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  ddr2_init_fsm #(
    .CNT_W (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .expired   (tmr_expired),
    .gap       (gap_q),
    .state_nxt (state_nxt),
    .step_nxt  (step_nxt),
    .load      (tmr_load),
    .load_val  (tmr_val)
  );

  ddr2_init_steps #(
    .ADDR_W   (ADDR_W),
    .BA_W     (BA_W),
    .CNT_W    (CNT_W),
    .T_MRD    (T_MRD),
    .T_RP     (T_RP),
    .T_RFC    (T_RFC),
    .T_DLL    (T_DLL),
    .MR_VAL   (MR_VAL),
    .EMR1_VAL (EMR1_VAL),
    .EMR2_VAL (EMR2_VAL),
    .EMR3_VAL (EMR3_VAL)
  ) u_steps (
    .step (step_nxt),
    .cmd  (rom_cmd),
    .ba   (rom_ba),
    .addr (rom_addr),
    .gap  (rom_gap)
  );

  // registered pin stage, aligned with FSM state
  logic              cke_n, done_n;
  cmd_e              cmd_n, cmd_q;
  logic [BA_W-1:0]   ba_n;
  logic [ADDR_W-1:0] addr_n;
  logic              cke_q, done_q;
  logic [BA_W-1:0]   ba_q;
  logic [ADDR_W-1:0] addr_q;

  always_comb begin
    cke_n  = (state_nxt != ST_WAIT);
    done_n = (state_nxt == ST_DONE);
    if (state_nxt == ST_CMD) begin
      cmd_n  = rom_cmd;
      ba_n   = rom_ba;
      addr_n = rom_addr;
    end else begin
      cmd_n  = CMD_NOP;
      ba_n   = '0;
      addr_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cke_q  <= 1'b0;
      done_q <= 1'b0;
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      gap_q  <= CNT_W'(T_RP);
    end else begin
      cke_q  <= cke_n;
      done_q <= done_n;
      cmd_q  <= cmd_n;
      ba_q   <= ba_n;
      addr_q <= addr_n;
      gap_q  <= rom_gap;
    end
  end

  assign cke       = cke_q;
  assign init_done = done_q;
  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign ba        = ba_q;
  assign addr      = addr_q;

endmodule

// File: rtl/ddr2_init_chk.sv
module ddr2_init_chk #(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned BA_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done
);

  logic [3:0] cmd;
  assign cmd = {cs_n, ras_n, cas_n, we_n};

  localparam logic [ADDR_W-1:0] A10_ONLY = ADDR_W'(1) << 10;

  // R2: bus idle while clock enable is low
  p_idle_while_cke_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (cmd == 4'b0111 && addr == '0 && ba == '0));

  // R2: clock enable never drops before reset
  p_cke_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);

  // R4: each command lasts one cycle
  p_single_cycle_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != 4'b0111) |=> (cmd == 4'b0111));

  // R8: precharge-all addresses all banks
  p_pch_all_banks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0010) |-> (addr == A10_ONLY && ba == '0));

  // R11: ready flag is sticky
  p_done_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R11: bus quiet with clock enabled once ready
  p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cke && cmd == 4'b0111));

endmodule

bind ddr2_init_seq ddr2_init_chk #(
  .ADDR_W (ADDR_W),
  .BA_W   (BA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cke       (cke),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .ba        (ba),
  .addr      (addr),
  .init_done (init_done)
);

// File: tb/ddr2_init_seq_tb.sv
module ddr2_init_seq_tb;

  localparam int unsigned STARTUP = 50;
  localparam int unsigned TMRD    = 2;
  localparam int unsigned TRP     = 3;
  localparam int unsigned TRFC    = 9;
  localparam int unsigned TDLL    = 200;
  localparam logic [13:0] MRV     = 14'h0052;
  localparam logic [13:0] EMR1V   = 14'h0386;
  localparam logic [13:0] EMR2V   = 14'h0080;
  localparam logic [13:0] EMR3V   = 14'h0011;

  logic        clk;
  logic        rst_n;
  logic        cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [2:0]  ba;
  logic [13:0] addr;

  int nchk  = 0;
  int nfail = 0;

  ddr2_init_seq #(
    .ADDR_W (14), .BA_W (3), .SYNC_STAGES (2), .STARTUP_CYC (STARTUP),
    .T_MRD (TMRD), .T_RP (TRP), .T_RFC (TRFC), .T_DLL (TDLL),
    .MR_VAL (MRV), .EMR1_VAL (EMR1V), .EMR2_VAL (EMR2V), .EMR3_VAL (EMR3V)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
    .cas_n (cas_n), .we_n (we_n), .ba (ba), .addr (addr), .init_done (init_done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // observation record
  logic [3:0]  s_cmd  [0:15];
  logic [2:0]  s_ba   [0:15];
  logic [13:0] s_addr [0:15];
  int          s_cyc  [0:15];
  int n_seen, cke_low, cke_rise, done_cyc, bad_cke, bad_done, bad_nop;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] e_cmd(input int k);
    case (k)
      0, 5:    return 4'b0010;
      6, 7:    return 4'b0001;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [2:0] e_ba(input int k);
    case (k)
      1:         return 3'd2;
      2:         return 3'd3;
      3, 9, 10:  return 3'd1;
      default:   return 3'd0;
    endcase
  endfunction

  function automatic logic [13:0] e_addr(input int k);
    case (k)
      0, 5:   return 14'h0400;
      6, 7:   return 14'h0000;
      1:      return EMR2V;
      2:      return EMR3V;
      3, 10:  return 14'h0006;   // EMR1V with [9:7]=000
      9:      return 14'h0386;   // EMR1V with [9:7]=111
      4:      return 14'h0152;   // MRV with bit 8 set
      default: return 14'h0052;  // MRV with bit 8 clear
    endcase
  endfunction

  function automatic int e_gap(input int k);
    case (k)
      0, 5:    return TRP;
      6, 7:    return TRFC;
      4:       return TDLL;
      default: return TMRD;
    endcase
  endfunction

  function automatic string addr_req(input int k);
    case (k)
      0, 5, 6, 7: return "R8";
      1, 2:       return "R5";
      4, 8:       return "R6";
      default:    return "R7";
    endcase
  endfunction

  // hold reset, check reset state (R1), release on a falling edge
  task automatic apply_reset(input int cycles);
    rst_n = 1'b0;
    repeat (cycles) @(negedge clk);
    chk(cke == 1'b0, "R1", "cke in reset", cke, 0);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1", "cmd in reset",
        {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk(addr == 14'h0 && ba == 3'h0, "R1", "addr/ba in reset", {ba, addr}, 0);
    chk(init_done == 1'b0, "R1", "done in reset", init_done, 0);
    rst_n = 1'b1;
  endtask

  task automatic observe(input int stop_after);
    logic [3:0] c;
    int cyc;
    cyc = 0; n_seen = 0; cke_low = 0; cke_rise = -1; done_cyc = -1;
    bad_cke = 0; bad_done = 0; bad_nop = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      cyc++;
      c = {cs_n, ras_n, cas_n, we_n};
      if (cke_rise < 0) begin
        if (!cke) begin
          cke_low++;
          if (c != 4'b0111) bad_nop++;
        end else begin
          cke_rise = cyc;
        end
      end else if (!cke) begin
        bad_cke++;
      end
      if (c != 4'b0111) begin
        if (n_seen < 16) begin
          s_cmd[n_seen] = c; s_ba[n_seen] = ba; s_addr[n_seen] = addr; s_cyc[n_seen] = cyc;
        end
        n_seen++;
        if (done_cyc >= 0) bad_done++;
      end else if (addr != 14'h0 || ba != 3'h0) begin
        bad_nop++;
      end
      if (done_cyc < 0 && init_done) done_cyc = cyc;
      else if (done_cyc >= 0 && !init_done) bad_done++;
      if (stop_after > 0 && n_seen >= stop_after) break;
      if (done_cyc >= 0 && cyc >= done_cyc + 20) break;
    end
  endtask

  task automatic check_sequence(input string scen);
    chk(cke_low >= STARTUP && cke_low <= STARTUP + 3, "R2",
        {scen, " cke low cycles"}, cke_low, STARTUP);
    chk(bad_cke == 0, "R2", {scen, " cke dropped"}, bad_cke, 0);
    chk(n_seen > 0 && s_cyc[0] == cke_rise + 1, "R3", {scen, " first cmd cycle"},
        (n_seen > 0) ? s_cyc[0] : -1, cke_rise + 1);
    chk(n_seen == 11, "R4", {scen, " command count"}, n_seen, 11);
    chk(bad_nop == 0, "R8", {scen, " idle bus not zero"}, bad_nop, 0);
    if (n_seen == 11) begin
      for (int k = 0; k < 11; k++) begin
        chk(s_cmd[k] == e_cmd(k), "R4", $sformatf("%s cmd %0d", scen, k), s_cmd[k], e_cmd(k));
        chk(s_ba[k] == e_ba(k), (e_cmd(k) == 4'b0000) ? "R5" : "R8",
            $sformatf("%s ba %0d", scen, k), s_ba[k], e_ba(k));
        chk(s_addr[k] == e_addr(k), addr_req(k),
            $sformatf("%s addr %0d", scen, k), s_addr[k], e_addr(k));
        if (k < 10)
          chk(s_cyc[k+1] - s_cyc[k] == e_gap(k), (e_cmd(k) == 4'b0000) ? "R9" : "R10",
              $sformatf("%s gap after %0d", scen, k), s_cyc[k+1] - s_cyc[k], e_gap(k));
      end
      chk(done_cyc - s_cyc[10] == TMRD, "R11", {scen, " done delay"},
          done_cyc - s_cyc[10], TMRD);
    end
    chk(done_cyc >= 0 && bad_done == 0, "R11", {scen, " done sticky and quiet"},
        bad_done, 0);
  endtask

  task automatic t_power_up;
    apply_reset(4);
    observe(0);
    check_sequence("power-up");
  endtask

  task automatic t_reset_in_wait;   // R12
    apply_reset(4);
    repeat (20) @(negedge clk);
    chk(cke == 1'b0, "R12", "cke low before re-reset", cke, 0);
    apply_reset(3);
    observe(0);
    check_sequence("R12 wait-restart");
  endtask

  task automatic t_reset_mid_list;  // R12
    apply_reset(4);
    observe(5);
    chk(n_seen == 5, "R12", "reached DLL reset load", n_seen, 5);
    #2 rst_n = 1'b0;
    #1;
    chk(cke == 1'b0 && init_done == 1'b0, "R12", "mid-list reset outputs",
        {cke, init_done}, 0);
    apply_reset(3);
    observe(0);
    check_sequence("R12 list-restart");
  endtask

  task automatic t_reset_after_done; // R13
    apply_reset(4);
    observe(0);
    chk(init_done == 1'b1, "R13", "done before reset", init_done, 1);
    #2 rst_n = 1'b0;
    #1;
    chk(init_done == 1'b0, "R13", "done cleared at reset", init_done, 0);
    chk(cke == 1'b0, "R13", "cke cleared at reset", cke, 0);
    apply_reset(3);
    observe(0);
    check_sequence("R13 rerun");
  endtask

  initial begin
    #(200000 * 20);
    nfail++;
    $display("FAIL watchdog: run did not finish (all requirements), actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    t_power_up();
    t_reset_in_wait();
    t_reset_mid_list();
    t_reset_after_done();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule